// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the next fetch address of a processor with 16-bit instruction addresses. It is consulted for every fetched instruction, not only for branches. The low bits of the fetch PC select one of eight entries. If that entry is valid and its stored tag equals the whole fetch PC, the block returns the stored next-PC. In every other case it returns the fetch PC plus one.

The lookup path is purely combinational, so the prediction is ready in the same fetch cycle. When the execute stage finds a mispredicted instruction, it raises the training strobe and supplies that instruction's PC and its resolved next PC. The entry that PC indexes is then overwritten on the next clock edge. The block does not detect mispredictions, squash instructions or keep direction counters. It only stores and returns targets.

Top module: `branch_target_buffer`

## Requirements
- R1: While reset is high and after it falls, every entry is invalid, so each lookup before any training returns the fetch PC plus one.
- R2: On a miss, the prediction is the fetch PC plus one, wrapping modulo 2^16 (0xFFFF predicts 0x0000).
- R3: After a training write of (PC p, target t), a lookup of p in any later cycle returns t until the entry is overwritten.
- R4: A hit requires all 16 tag bits to equal the fetch PC. A PC that shares the low three index bits with a trained PC but differs in any higher bit misses.
- R5: Bits [2:0] of the PC select the entry. Each of the eight entries holds its own tag and target, and a write changes only the entry its index selects.
- R6: Training a different PC into an occupied index replaces the entry. The previous PC then misses.
- R7: A training write and a lookup of the same index in the same cycle return the old contents. The new entry is seen from the next cycle.
- R8: While the training strobe is low, the training PC and target inputs have no effect on any entry.
- R9: Training a PC that is already stored replaces its target with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, invalidates all entries |
| fetch_pc | input | 16 | PC of the instruction being fetched |
| pred_pc | output | 16 | Predicted next PC (combinational) |
| upd_en | input | 1 | Training strobe from execute on a misprediction |
| upd_pc | input | 16 | PC of the mispredicted instruction |
| upd_target | input | 16 | Resolved correct next PC |

## Verification
The bench drives lookups of PCs that alias on the index but differ in their upper bits. A design that compares only part of the tag would return a foreign target for these. It also looks up 0xFFFF on a miss, which catches an increment that does not wrap. It trains every index and then reads each one back, so a wrong index slice or a write that spills into another entry shows up as a wrong target. The bench also holds junk on the training inputs with the strobe low. Finally, it looks up an index in the same cycle it is written: a design that forwards the write would return the new target one cycle early.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned DEF_PC_W  = 16;
  localparam int unsigned DEF_IDX_W = 3;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned PC_W  = btb_pkg::DEF_PC_W,
  parameter int unsigned IDX_W = btb_pkg::DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PC_W-1:0]  rd_tag,
  output logic [PC_W-1:0]  rd_tgt
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [PC_W-1:0]  tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  // Tag and target arrays carry no reset so they map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_tgt   = tgt_mem[rd_idx];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> valid_q == '0);
  // R5
  one_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_q ^ $past(valid_q)) <= 1);
  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q & $past(valid_q)) == $past(valid_q));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> valid_q == $past(valid_q));
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W = btb_pkg::DEF_PC_W
) (
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            ent_valid,
  input  logic [PC_W-1:0] ent_tag,
  input  logic [PC_W-1:0] ent_tgt,
  output logic            hit,
  output logic [PC_W-1:0] pred
);
  logic [PC_W-1:0] seq_pc;

  always_comb begin
    seq_pc = fetch_pc + PC_W'(1);
    hit    = ent_valid && (ent_tag == fetch_pc);
    pred   = hit ? ent_tgt : seq_pc;
  end
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int unsigned PC_W  = btb_pkg::DEF_PC_W,
  parameter int unsigned IDX_W = btb_pkg::DEF_IDX_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_pc,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target
);
  logic            ent_valid;
  logic [PC_W-1:0] ent_tag;
  logic [PC_W-1:0] ent_tgt;
  logic            hit;

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (upd_en),
    .wr_idx   (upd_pc[IDX_W-1:0]),
    .wr_tag   (upd_pc),
    .wr_tgt   (upd_target),
    .rd_idx   (fetch_pc[IDX_W-1:0]),
    .rd_valid (ent_valid),
    .rd_tag   (ent_tag),
    .rd_tgt   (ent_tgt)
  );

  btb_lookup #(.PC_W(PC_W)) u_lookup (
    .fetch_pc  (fetch_pc),
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .ent_tgt   (ent_tgt),
    .hit       (hit),
    .pred      (pred_pc)
  );

  // R3
  trained_hit_chk: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (fetch_pc != $past(upd_pc) || pred_pc == $past(upd_target)));
  // R8
  stable_pred_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(upd_en) && $stable(fetch_pc)) |-> $stable(pred_pc));
  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> pred_pc == fetch_pc + PC_W'(1));
endmodule

// File: tb/test_branch_target_buffer.sv
module test_branch_target_buffer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] fetch_pc = '0;
  logic [15:0] pred_pc;
  logic        upd_en = 1'b0;
  logic [15:0] upd_pc = '0;
  logic [15:0] upd_target = '0;

  typedef struct {
    logic [15:0] pc;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_buffer i_branch_target_buffer (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_pc(pred_pc),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_target(upd_target)
  );

  // Monitor: compares each queued expectation at the falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pred_pc !== it.exp) begin
        errors++;
        $display("FAIL %s: pc=%h actual=%h expected=%h", it.req, it.pc, pred_pc, it.exp);
      end
    end
  end

  task automatic look(input logic [15:0] pc, input logic [15:0] exp, input string req);
    @(posedge clk); #1;
    upd_en = 1'b0; fetch_pc = pc;
    q.push_back('{pc, exp, req});
  endtask

  task automatic train(input logic [15:0] pc, input logic [15:0] tgt);
    @(posedge clk); #1;
    upd_en = 1'b1; upd_pc = pc; upd_target = tgt;
  endtask

  task automatic look_train(input logic [15:0] pc, input logic [15:0] exp,
                            input logic [15:0] tpc, input logic [15:0] tgt, input string req);
    @(posedge clk); #1;
    fetch_pc = pc; upd_en = 1'b1; upd_pc = tpc; upd_target = tgt;
    q.push_back('{pc, exp, req});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset itself, then lookups right after release
    #1; q.push_back('{16'h0000, 16'h0001, "R1"});
    @(posedge clk); #1; rst = 1'b0;
    look(16'h0000, 16'h0001, "R1");
    look(16'h1234, 16'h1235, "R1");
    look(16'hFFFF, 16'h0000, "R2");
    look(16'h7FFF, 16'h8000, "R2");
    train(16'h0010, 16'h0200);
    look(16'h0010, 16'h0200, "R3");
    look(16'h0018, 16'h0019, "R4");
    look(16'h8010, 16'h8011, "R4");
    look(16'h0010, 16'h0200, "R3");
    for (int i = 0; i < 8; i++) train(16'h0100 + 16'(i), 16'h0A00 + 16'(i * 3));
    for (int i = 0; i < 8; i++) look(16'h0100 + 16'(i), 16'h0A00 + 16'(i * 3), "R5");
    look(16'h0010, 16'h0011, "R6");
    train(16'h0103, 16'h7777);
    look(16'h0103, 16'h7777, "R9");
    look(16'h0104, 16'h0A0C, "R5");
    // R8: junk on training inputs with the strobe low
    @(posedge clk); #1;
    upd_en = 1'b0; upd_pc = 16'h0104; upd_target = 16'h1111;
    @(posedge clk); #1;
    upd_pc = 16'h0105; upd_target = 16'h2222;
    look(16'h0104, 16'h0A0C, "R8");
    look(16'h0105, 16'h0A0F, "R8");
    // R7: same-cycle write and lookup of one index
    look_train(16'h0102, 16'h0A06, 16'h0102, 16'h4444, "R7");
    look(16'h0102, 16'h4444, "R7");
    look_train(16'h0106, 16'h0A12, 16'hC006, 16'hFFFF, "R7");
    look(16'h0106, 16'h0107, "R6");
    look(16'hC006, 16'hFFFF, "R3");
    @(posedge clk); @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule